// File: doc/BRIEF.md
# Occupancy Counter with Restore-N

This block keeps the occupancy count of a small shift-register FIFO that can restore elements it has already read. It takes up to three commands in each cycle. A write strobe adds one. A read strobe takes one away. An unsigned restore amount puts back that many previously read elements. The counter is one bit wider than the FIFO address, and it resets to all ones. Read as a signed number, the count plus one is the occupancy, so the top bit doubles as the empty indication.

The block drives two outputs. One is the registered count. The other is the value the register will load at the next clock edge, produced combinationally. An enclosing FIFO can use that next value to register its full or overflow flags with no extra cycle of latency. The counter flags no misuse of its own, and its arithmetic wraps modulo two to the power of the counter width.

Top module: `occ_counter`

## Requirements
- R1: The counter width is the parameter CNT_W (default 5). The restore input `addN` is CNT_W-1 bits wide and is zero-extended before it is added.
- R2: While `rst` is high at a rising edge, the count loads all ones (signed -1, FIFO empty). This applies whatever the command inputs are.
- R3: At each rising edge with `rst` low, `count` takes the value that `countNext` showed just before that edge.
- R4: With `incr` high, `decr` low and `addN` zero, the next count is the count plus one.
- R5: With `decr` high and `incr` low, the next count is the count minus one.
- R6: With `incr` and `decr` both high, the next count equals the current count.
- R7: While `decr` is high, `addN` has no effect on the next count, even when it is non-zero.
- R8: With `decr` low, the next count is the count plus `incr` plus `addN`, so a write and a restore can happen in the same cycle.
- R9: All arithmetic wraps modulo 2^CNT_W. For example, 20 plus 12 gives 0, and 31 plus 16 gives 15 at CNT_W=5. No error is raised.
- R10: `countNext` follows the command inputs combinationally, within the same cycle and before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| incr | input | 1 | Write strobe: add one |
| decr | input | 1 | Read strobe: subtract one, overrides addN |
| addN | input | CNT_W-1 | Number of read elements to restore |
| count | output | CNT_W | Registered count (occupancy minus one, signed) |
| countNext | output | CNT_W | Value the count loads at the next edge |

## Verification
The bench builds the block with CNT_W at its default of 5. At that width the whole 32-value space wraps within a few commands, so both the upward wrap past 31 and the downward step through the all-ones empty state come up in the directed table. A maximal restore amount of 15 combined with a write also reaches every carry path of the adder. A random run then sets all command combinations against an integer model, and the bench compares `countNext` before the edge and `count` after it.

// File: rtl/occ_pkg.sv
package occ_pkg;

  // Strobes passed from command decode to the arithmetic datapath
  typedef struct packed {
    logic stepDown;  // subtract one (read without write)
    logic plusOne;   // add one (write without read)
    logic takeN;     // restore amount participates (no read)
  } occ_strobe_t;

endpackage

// File: rtl/occ_ctrl.sv
module occ_ctrl
  import occ_pkg::*;
(
  input  logic        incr,
  input  logic        decr,
  output occ_strobe_t strobe
);

  // A read cancels the restore amount. A read paired with a write nets to zero.
  always_comb begin
    strobe.stepDown = decr & ~incr;
    strobe.plusOne  = incr & ~decr;
    strobe.takeN    = ~decr;
  end

endmodule

// File: rtl/occ_dp.sv
module occ_dp
  import occ_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  occ_strobe_t       strobe,
  input  logic [CNT_W-2:0]  addN,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  countNext
);

  localparam int ADDR_W = CNT_W - 1;

  logic [CNT_W-1:0] nExt;
  logic [CNT_W-1:0] upDelta;

  // Zero-extend the restore amount by one bit (R1)
  assign nExt = strobe.takeN ? {1'b0, addN} : '0;

  always_comb begin
    upDelta = nExt + {{ADDR_W{1'b0}}, strobe.plusOne};
    if (strobe.stepDown)
      countNext = count - {{ADDR_W{1'b0}}, 1'b1};
    else
      countNext = count + upDelta;  // wraps modulo 2^CNT_W
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '1;
    else     count <= countNext;
  end

endmodule

// File: rtl/occ_counter.sv
module occ_counter
  import occ_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             incr,
  input  logic             decr,
  input  logic [CNT_W-2:0] addN,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] countNext
);

  occ_strobe_t strobe;

  occ_ctrl uCtrl (
    .incr   (incr),
    .decr   (decr),
    .strobe (strobe)
  );

  occ_dp #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .addN      (addN),
    .count     (count),
    .countNext (countNext)
  );

endmodule

// File: rtl/occ_counter_chk.sv
module occ_counter_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             incr,
  input logic             decr,
  input logic [CNT_W-2:0] addN,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] countNext
);

  logic [CNT_W-1:0] oneW;
  logic [CNT_W-1:0] addSum;
  assign oneW   = {{(CNT_W-1){1'b0}}, 1'b1};
  assign addSum = count + {1'b0, addN} + {{(CNT_W-1){1'b0}}, incr};

  // R2: reset loads all ones
  a_r2_reset_ones: assert property (@(posedge clk) rst |=> count == '1);

  // R3: register follows the exposed next value
  a_r3_loads_next: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> count == $past(countNext));

  // R5 and R7: a read alone steps down, whatever addN is
  a_r7_read_ignores_n: assert property (@(posedge clk) disable iff (rst)
    (decr && !incr) |-> countNext == count - oneW);

  // R6: read and write together hold the count
  a_r6_both_hold: assert property (@(posedge clk) disable iff (rst)
    (decr && incr) |-> countNext == count);

  // R8: without a read, write and restore add together
  a_r8_write_restore: assert property (@(posedge clk) disable iff (rst)
    !decr |-> countNext == addSum);

endmodule

bind occ_counter occ_counter_chk #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .incr      (incr),
  .decr      (decr),
  .addN      (addN),
  .count     (count),
  .countNext (countNext)
);

// File: tb/occ_counter_test.sv
`timescale 1ns/1ps
module occ_counter_test;

  localparam int CNT_W = 5;
  localparam int MODV  = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic incr = 1'b0;
  logic decr = 1'b0;
  logic [CNT_W-2:0] addN = '0;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] countNext;

  int nApplied = 0;
  int nBad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  occ_counter #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .incr(incr), .decr(decr), .addN(addN),
    .count(count), .countNext(countNext)
  );

  // Vector layout: {incr, decr, addN[3:0], expected count[4:0]}
  localparam int NVEC = 16;
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 4'd0,  5'd0 },  // R4 from empty: 31+1 wraps to 0
    {1'b1, 1'b0, 4'd0,  5'd1 },  // R4
    {1'b0, 1'b0, 4'd3,  5'd4 },  // R8 restore only
    {1'b1, 1'b0, 4'd2,  5'd7 },  // R8 write plus restore
    {1'b0, 1'b1, 4'd0,  5'd6 },  // R5
    {1'b0, 1'b1, 4'd9,  5'd5 },  // R7 addN ignored
    {1'b1, 1'b1, 4'd4,  5'd5 },  // R6 and R7
    {1'b1, 1'b1, 4'd0,  5'd5 },  // R6
    {1'b0, 1'b0, 4'd0,  5'd5 },  // idle hold
    {1'b0, 1'b0, 4'd15, 5'd20},  // R8 max restore
    {1'b1, 1'b0, 4'd11, 5'd0 },  // R9 wrap up: 20+12
    {1'b0, 1'b1, 4'd0,  5'd31},  // R9 wrap down to empty
    {1'b0, 1'b1, 4'd0,  5'd30},  // R5
    {1'b1, 1'b0, 4'd15, 5'd14},  // R9: 30+16
    {1'b0, 1'b1, 4'd15, 5'd13},  // R7
    {1'b1, 1'b0, 4'd0,  5'd14}   // R4
  };

  task automatic check(input string req, input int act, input int exp);
    nApplied++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at negedge, check countNext before the edge (R10), count after it (R3)
  task automatic applyCmd(input logic i, input logic d, input logic [CNT_W-2:0] n,
                          input int exp, input string req);
    @(negedge clk);
    incr = i; decr = d; addN = n;
    #1;
    check({req, " next (R10)"}, int'(countNext), exp);
    @(posedge clk);
    #1;
    check({req, " count (R3)"}, int'(count), exp);
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nApplied, nBad);
      $finish;
    end
  end

  initial begin
    int model;
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset value", int'(count), MODV - 1);
    @(negedge clk);
    rst = 1'b0;

    // Table walk (R1 widths implied by the 4-bit addN field)
    for (int k = 0; k < NVEC; k++) begin
      applyCmd(VEC[k][10], VEC[k][9], VEC[k][8:5], int'(VEC[k][4:0]), $sformatf("vec%0d", k));
    end

    // R2: reset mid-run with commands active
    @(negedge clk);
    rst = 1'b1; incr = 1'b1; decr = 1'b0; addN = 4'd7;
    @(posedge clk); #1;
    check("R2 reset overrides commands", int'(count), MODV - 1);
    @(negedge clk);
    rst = 1'b0; incr = 1'b0; addN = '0;

    // Random commands against an integer model (R4..R9)
    model = MODV - 1;
    for (int k = 0; k < 400; k++) begin
      logic ri, rd;
      logic [CNT_W-2:0] rn;
      ri = 1'($urandom_range(0, 1));
      rd = 1'($urandom_range(0, 1));
      rn = (CNT_W-1)'($urandom_range(0, (MODV/2) - 1));
      if (rd) model = model - 1 + int'(ri);
      else    model = model + int'(ri) + int'(rn);
      model = ((model % MODV) + MODV) % MODV;
      applyCmd(ri, rd, rn, model, "R8 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nBad);
    $finish;
  end

endmodule